// File: doc/BRIEF.md
# Memory Regulator Configuration Serial Slave

This block is the two-wire serial target that holds the output settings of a dual buck regulator for a memory subsystem. It runs entirely on the system clock. The clock and data lines arrive already synchronized, and the block pulls the data line low through an open-drain enable. It recognises bus START and STOP conditions and takes in an address byte, a register pointer and data bytes. It supports single-byte writes, and reads that set the pointer in a write phase and then use a repeated START.

Four configuration fields drive the regulator through registered outputs: a switching-frequency select, a start-up voltage select, a DAC offset code and an output slew select. A write with the all-ones DAC code does not change the offset. It raises a shutdown request instead. A write of any other illegal code is dropped, so the outputs only ever carry defined settings.

A stall timer releases the bus if the clock line stays low for too long during a transaction. This keeps a stuck master from holding the data line low for ever.

Top module: `pmic_cfg_slave`

## Requirements
- R1: After reset the outputs are:
  - freq_sel = 0
  - vsel = 2
  - dac_ofs = 0
  - slew_sel = 0
  - shdn_req = 0
  - sda_oe = 0 (data line released)
- R2: The target ACKs the address bytes 0x2A (write) and 0x2B (read), that is 7-bit address 0x15 plus the direction bit. It NACKs every other address byte and also leaves the following bytes of that transaction unacknowledged. An ACK is sda_oe = 1 during the ninth clock.
- R3: A write transaction consists of the address byte 0x2A, a pointer byte, then a data byte. It updates the field that the pointer selects:
  - 0x01 bits [2:0] go to freq_sel
  - 0x02 bits [1:0] go to vsel
  - 0x03 bits [5:0] go to dac_ofs
  - 0x04 bits [1:0] go to slew_sel
- R4: A read transaction consists of 0x2A, the pointer, a repeated START, 0x2B, then the target sends the byte most significant bit first. Bits outside a field read as 0 and are ignored on write.
- R5: Frequency codes 6 and 7 are reserved. Writing one of them leaves freq_sel unchanged, so freq_sel never exceeds 5.
- R6: DAC codes 51 to 62 are reserved. Writing one of them leaves dac_ofs unchanged, so dac_ofs never exceeds 50.
- R7: Writing DAC code 63 does the following:
  - it sets shdn_req
  - it keeps dac_ofs unchanged
  - pointer 0x03 reads 0x3F while the request is pending
  - a later legal DAC code clears shdn_req and loads dac_ofs
- R8: Any other pointer value is ACKed. A data byte written to it has no effect, and a read from it returns 0x00.
- R9: If the clock line stays low for TIMEOUT_CYC cycles during a transaction, the target returns to idle and releases the data line. A following transaction works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line (wired level) |
| sda_oe | output | 1 | Pull data line low when 1 |
| freq_sel | output | 3 | Switching frequency code |
| vsel | output | 2 | Start-up output voltage code |
| dac_ofs | output | 6 | DAC offset code, 10 mV steps |
| slew_sel | output | 2 | Output slew code |
| shdn_req | output | 1 | Chip shutdown request |

## Verification
The bench aims at the code-range boundaries of each field:
- Frequency codes 5, 6 and 7 are tested. A design that stores any written value would move freq_sel to a reserved code.
- DAC codes 50, 51, 62 and 63 are tested. A design that stores any written value would move dac_ofs to a reserved code.
- Code 63 is checked for two faults: a design that stores it as an offset, and a design that never clears the request afterwards.
- Wrong addresses are checked for a false ACK, and for data bytes that still leak into the registers.
- An unmapped pointer must not alias onto a real field.
- A transaction stalled while the target drives a zero must end with the line released. A design without a working timer would hold the bus low indefinitely.

// File: rtl/pmic_cfg_pkg.sv
package pmic_cfg_pkg;

  localparam int BYTE_W = 8;
  localparam logic [6:0] DEV_ADDR7 = 7'h15;

  localparam int FREQ_W = 3;
  localparam int VSEL_W = 2;
  localparam int DAC_W  = 6;
  localparam int SLEW_W = 2;

  localparam logic [BYTE_W-1:0] PTR_FREQ = 8'h01;
  localparam logic [BYTE_W-1:0] PTR_VSEL = 8'h02;
  localparam logic [BYTE_W-1:0] PTR_DAC  = 8'h03;
  localparam logic [BYTE_W-1:0] PTR_SLEW = 8'h04;

  localparam logic [FREQ_W-1:0] FREQ_RST = 3'd0;
  localparam logic [FREQ_W-1:0] FREQ_MAX = 3'd5;
  localparam logic [VSEL_W-1:0] VSEL_RST = 2'd2;
  localparam logic [VSEL_W-1:0] VSEL_MAX = 2'd3;
  localparam logic [DAC_W-1:0]  DAC_RST  = 6'd0;
  localparam logic [DAC_W-1:0]  DAC_MAX  = 6'd50;
  localparam logic [DAC_W-1:0]  DAC_SHDN = 6'h3F;
  localparam logic [SLEW_W-1:0] SLEW_RST = 2'd0;
  localparam logic [SLEW_W-1:0] SLEW_MAX = 2'd3;

  typedef enum logic [2:0] {
    LS_IDLE,
    LS_ADDR,
    LS_PTR,
    LS_WR,
    LS_ACK,
    LS_RD,
    LS_RACK
  } link_state_t;

endpackage

// File: rtl/smb_line_events.sv
module smb_line_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  // data edges while the clock stays high frame a transaction
  assign bus_start = scl_i & scl_q & sda_q & ~sda_i;
  assign bus_stop  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/smb_stall_timer.sv
module smb_stall_timer #(
  parameter int TIMEOUT_CYC = 3_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic busy,
  output logic tmo
);

  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || scl_i || !busy) begin
      cnt <= '0;
      tmo <= 1'b0;
    end else if (cnt == LAST) begin
      cnt <= '0;
      tmo <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
      tmo <= 1'b0;
    end
  end

endmodule

// File: rtl/smb_link_fsm.sv
module smb_link_fsm
  import pmic_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_i,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              bus_tmo,
  input  logic [BYTE_W-1:0] rdata,
  output logic              busy,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [BYTE_W-1:0] ptr,
  output logic [BYTE_W-1:0] wdata
);

  localparam int BC_W = $clog2(BYTE_W + 1);
  localparam logic [BC_W-1:0] BC_FULL = BC_W'(BYTE_W);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(BYTE_W - 1);

  link_state_t       state;
  link_state_t       after_ack;
  logic [BYTE_W-1:0] shreg;
  logic [BC_W-1:0]   bitcnt;
  logic              mack;

  assign busy = (state != LS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= LS_IDLE;
      after_ack <= LS_IDLE;
      shreg     <= '0;
      bitcnt    <= '0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      wr_en     <= 1'b0;
      ptr       <= '0;
      wdata     <= '0;
    end else begin
      wr_en <= 1'b0;
      if (bus_tmo || bus_stop) begin
        state  <= LS_IDLE;
        sda_oe <= 1'b0;
      end else if (bus_start) begin
        state  <= LS_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          LS_ADDR, LS_PTR, LS_WR: begin
            if (scl_rise && bitcnt != BC_FULL) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_i};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == BC_FULL) begin
              bitcnt <= '0;
              if (state == LS_ADDR) begin
                if (shreg[BYTE_W-1:1] == DEV_ADDR7) begin
                  sda_oe    <= 1'b1;
                  state     <= LS_ACK;
                  after_ack <= shreg[0] ? LS_RD : LS_PTR;
                end else begin
                  state <= LS_IDLE;
                end
              end else if (state == LS_PTR) begin
                ptr       <= shreg;
                sda_oe    <= 1'b1;
                state     <= LS_ACK;
                after_ack <= LS_WR;
              end else begin
                wdata     <= shreg;
                wr_en     <= 1'b1;
                sda_oe    <= 1'b1;
                state     <= LS_ACK;
                after_ack <= LS_WR;
              end
            end
          end
          LS_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              state  <= after_ack;
              if (after_ack == LS_RD) begin
                shreg  <= rdata;
                sda_oe <= ~rdata[BYTE_W-1];
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
          LS_RD: begin
            if (scl_fall) begin
              if (bitcnt == BC_LAST) begin
                sda_oe <= 1'b0;
                state  <= LS_RACK;
              end else begin
                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                sda_oe <= ~shreg[BYTE_W-2];
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          LS_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_i;
            end else if (scl_fall) begin
              if (mack) begin
                shreg  <= rdata;
                sda_oe <= ~rdata[BYTE_W-1];
                bitcnt <= '0;
                state  <= LS_RD;
              end else begin
                state <= LS_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfg_field.sv
module cfg_field #(
  parameter int           W   = 2,
  parameter logic [W-1:0] RST = '0,
  parameter logic [W-1:0] MAX = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (MAX == {W{1'b1}}) begin : g_full_range
      always_ff @(posedge clk) begin
        if (rst)     q <= RST;
        else if (we) q <= d;
      end
    end else begin : g_limited
      always_ff @(posedge clk) begin
        if (rst)                  q <= RST;
        else if (we && d <= MAX)  q <= d;
      end
    end
  endgenerate

endmodule

// File: rtl/cfg_regmap.sv
module cfg_regmap
  import pmic_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] ptr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic [FREQ_W-1:0] freq_sel,
  output logic [VSEL_W-1:0] vsel,
  output logic [DAC_W-1:0]  dac_ofs,
  output logic [SLEW_W-1:0] slew_sel,
  output logic              shdn_req
);

  logic             unused_hi;
  logic [DAC_W-1:0] dac_in;

  assign unused_hi = ^wdata[BYTE_W-1:DAC_W];
  assign dac_in    = wdata[DAC_W-1:0];

  cfg_field #(.W(FREQ_W), .RST(FREQ_RST), .MAX(FREQ_MAX)) u_freq (
    .clk(clk), .rst(rst), .we(wr_en && ptr == PTR_FREQ),
    .d(wdata[FREQ_W-1:0]), .q(freq_sel)
  );

  cfg_field #(.W(VSEL_W), .RST(VSEL_RST), .MAX(VSEL_MAX)) u_vsel (
    .clk(clk), .rst(rst), .we(wr_en && ptr == PTR_VSEL),
    .d(wdata[VSEL_W-1:0]), .q(vsel)
  );

  cfg_field #(.W(SLEW_W), .RST(SLEW_RST), .MAX(SLEW_MAX)) u_slew (
    .clk(clk), .rst(rst), .we(wr_en && ptr == PTR_SLEW),
    .d(wdata[SLEW_W-1:0]), .q(slew_sel)
  );

  // the offset field carries one command code beside its legal range
  always_ff @(posedge clk) begin
    if (rst) begin
      dac_ofs  <= DAC_RST;
      shdn_req <= 1'b0;
    end else if (wr_en && ptr == PTR_DAC) begin
      if (dac_in == DAC_SHDN) begin
        shdn_req <= 1'b1;
      end else if (dac_in <= DAC_MAX) begin
        dac_ofs  <= dac_in;
        shdn_req <= 1'b0;
      end
    end
  end

  always_comb begin
    case (ptr)
      PTR_FREQ: rdata = {{(BYTE_W-FREQ_W){1'b0}}, freq_sel};
      PTR_VSEL: rdata = {{(BYTE_W-VSEL_W){1'b0}}, vsel};
      PTR_DAC:  rdata = {{(BYTE_W-DAC_W){1'b0}}, (shdn_req ? DAC_SHDN : dac_ofs)};
      PTR_SLEW: rdata = {{(BYTE_W-SLEW_W){1'b0}}, slew_sel};
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/pmic_cfg_slave.sv
module pmic_cfg_slave
  import pmic_cfg_pkg::*;
#(
  parameter int TIMEOUT_CYC = 3_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [FREQ_W-1:0] freq_sel,
  output logic [VSEL_W-1:0] vsel,
  output logic [DAC_W-1:0]  dac_ofs,
  output logic [SLEW_W-1:0] slew_sel,
  output logic              shdn_req
);

  logic              scl_rise;
  logic              scl_fall;
  logic              bus_start;
  logic              bus_stop;
  logic              bus_tmo;
  logic              busy;
  logic              wr_en;
  logic [BYTE_W-1:0] ptr;
  logic [BYTE_W-1:0] wdata;
  logic [BYTE_W-1:0] rdata;

  smb_line_events u_events (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  smb_stall_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst(rst), .scl_i(scl_i), .busy(busy), .tmo(bus_tmo)
  );

  smb_link_fsm u_link (
    .clk(clk), .rst(rst), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop), .bus_tmo(bus_tmo),
    .rdata(rdata), .busy(busy), .sda_oe(sda_oe),
    .wr_en(wr_en), .ptr(ptr), .wdata(wdata)
  );

  cfg_regmap u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .ptr(ptr), .wdata(wdata),
    .rdata(rdata), .freq_sel(freq_sel), .vsel(vsel), .dac_ofs(dac_ofs),
    .slew_sel(slew_sel), .shdn_req(shdn_req)
  );

endmodule

// File: rtl/pmic_cfg_slave_chk.sv
module pmic_cfg_slave_chk
  import pmic_cfg_pkg::*;
#(
  parameter int TIMEOUT_CYC = 3_000_000
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [FREQ_W-1:0] freq_sel,
  input logic [VSEL_W-1:0] vsel,
  input logic [DAC_W-1:0]  dac_ofs,
  input logic [SLEW_W-1:0] slew_sel,
  input logic              shdn_req
);

  logic [31:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || scl_i)        low_run <= '0;
    else if (low_run != '1)  low_run <= low_run + 1'b1;
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!sda_oe && freq_sel == FREQ_RST && vsel == VSEL_RST &&
                    dac_ofs == DAC_RST && slew_sel == SLEW_RST && !shdn_req));

  assert_drive_on_low_clock_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);

  assert_freq_legal_R5: assert property (@(posedge clk) disable iff (rst)
    freq_sel <= FREQ_MAX);

  assert_dac_legal_R6: assert property (@(posedge clk) disable iff (rst)
    dac_ofs <= DAC_MAX);

  assert_shdn_keeps_ofs_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(shdn_req) |-> $stable(dac_ofs));

  assert_stall_release_R9: assert property (@(posedge clk) disable iff (rst)
    (low_run > 32'(TIMEOUT_CYC) + 32'd4) |-> !sda_oe);

endmodule

bind pmic_cfg_slave pmic_cfg_slave_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .freq_sel(freq_sel), .vsel(vsel), .dac_ofs(dac_ofs),
  .slew_sel(slew_sel), .shdn_req(shdn_req)
);

// File: tb/pmic_cfg_slave_test.sv
module pmic_cfg_slave_test;

  localparam int TMO  = 400;
  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_line;
  logic       sda_oe;
  logic [2:0] freq_sel;
  logic [1:0] vsel;
  logic [5:0] dac_ofs;
  logic [1:0] slew_sel;
  logic       shdn_req;

  always #5 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  pmic_cfg_slave #(.TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .freq_sel(freq_sel), .vsel(vsel), .dac_ofs(dac_ofs),
    .slew_sel(slew_sel), .shdn_req(shdn_req)
  );

  // scoreboard
  string       exp_tag[$];
  logic [15:0] exp_val[$];
  logic [15:0] obs_val;
  event        obs_ev;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  // bench model of the configuration
  logic [2:0] mf = 3'd0;
  logic [1:0] mv = 2'd2;
  logic [5:0] md = 6'd0;
  logic [1:0] ms = 2'd0;
  logic       mx = 1'b0;

  task automatic push_exp(input string tag, input logic [15:0] v);
    exp_tag.push_back(tag);
    exp_val.push_back(v);
  endtask

  task automatic observe(input logic [15:0] v);
    obs_val = v;
    -> obs_ev;
    #1;
  endtask

  initial begin
    forever begin
      @(obs_ev);
      if (exp_val.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard underrun: actual %h expected none", obs_val);
      end else begin
        string       t;
        logic [15:0] e;
        t = exp_tag.pop_front();
        e = exp_val.pop_front();
        n_chk++;
        if (obs_val !== e)  begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", t, obs_val, e);
        end
      end
    end
  end

  task automatic wt();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt();
    m_scl = 1'b1; wt();
    m_sda = 1'b0; wt();
    m_scl = 1'b0; wt();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt();
    m_scl = 1'b1; wt();
    m_sda = 1'b1; wt();
  endtask

  task automatic send_byte(input logic [7:0] b, input logic ack_exp, input string tag);
    push_exp(tag, {15'd0, ack_exp});
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wt();
      m_scl = 1'b1; wt();
      m_scl = 1'b0; wt();
    end
    m_sda = 1'b1; wt();
    m_scl = 1'b1; wt();
    observe({15'd0, ~sda_line});
    m_scl = 1'b0; wt();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wt();
      m_scl = 1'b1; wt();
      v[i] = sda_line;
      m_scl = 1'b0; wt();
    end
    m_sda = ~mack; wt();
    m_scl = 1'b1; wt();
    m_scl = 1'b0; wt();
    m_sda = 1'b1;
  endtask

  task automatic chk_outs(input string tag);
    push_exp(tag, {2'b0, mx, ms, md, mv, mf});
    observe({2'b0, shdn_req, slew_sel, dac_ofs, vsel, freq_sel});
  endtask

  task automatic wr_reg(input logic [7:0] p, input logic [7:0] d, input string tag);
    bus_start();
    send_byte(8'h2A, 1'b1, tag);
    send_byte(p, 1'b1, tag);
    send_byte(d, 1'b1, tag);
    bus_stop();
    wt();
  endtask

  task automatic rd_reg(input logic [7:0] p, input logic [7:0] e, input string tag);
    logic [7:0] v;
    bus_start();
    send_byte(8'h2A, 1'b1, tag);
    send_byte(p, 1'b1, tag);
    bus_start();
    send_byte(8'h2B, 1'b1, tag);
    recv_byte(1'b0, v);
    push_exp(tag, {8'd0, e});
    observe({8'd0, v});
    bus_stop();
    wt();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    wt();

    // R1 reset state and released line
    chk_outs("R1");
    push_exp("R1", 16'd1);
    observe({15'd0, sda_line});

    // R3 basic writes to every field
    wr_reg(8'h01, 8'h05, "R3"); mf = 3'd5; chk_outs("R3");
    wr_reg(8'h02, 8'h03, "R3"); mv = 2'd3;
    wr_reg(8'h04, 8'h02, "R3"); ms = 2'd2;
    wr_reg(8'h03, 8'h32, "R3"); md = 6'd50; chk_outs("R3");

    // R5 reserved frequency codes and reserved upper bits
    wr_reg(8'h01, 8'h07, "R5"); chk_outs("R5");
    wr_reg(8'h01, 8'h06, "R5"); chk_outs("R5");
    wr_reg(8'h01, 8'hF9, "R5"); mf = 3'd1; chk_outs("R5");

    // R4 reads
    rd_reg(8'h01, 8'h01, "R4");
    rd_reg(8'h02, 8'h03, "R4");
    rd_reg(8'h04, 8'h02, "R4");
    rd_reg(8'h03, 8'h32, "R4");

    // R2 foreign addresses are not acknowledged and change nothing
    bus_start();
    send_byte(8'h2C, 1'b0, "R2");
    send_byte(8'h01, 1'b0, "R2");
    send_byte(8'h00, 1'b0, "R2");
    bus_stop(); wt();
    chk_outs("R2");
    bus_start();
    send_byte(8'h54, 1'b0, "R2");
    bus_stop(); wt();

    // R6 reserved DAC codes
    wr_reg(8'h03, 8'd51, "R6"); chk_outs("R6");
    wr_reg(8'h03, 8'd62, "R6"); chk_outs("R6");

    // R7 shutdown command code
    wr_reg(8'h03, 8'h3F, "R7"); mx = 1'b1; chk_outs("R7");
    rd_reg(8'h03, 8'h3F, "R7");
    wr_reg(8'h03, 8'h0A, "R7"); mx = 1'b0; md = 6'd10; chk_outs("R7");

    // R8 unmapped pointers
    wr_reg(8'h07, 8'h55, "R8"); chk_outs("R8");
    rd_reg(8'h07, 8'h00, "R8");
    wr_reg(8'h00, 8'hFF, "R8"); chk_outs("R8");
    rd_reg(8'h00, 8'h00, "R8");

    // R9 stall while the target drives a zero
    bus_start();
    send_byte(8'h2A, 1'b1, "R9");
    send_byte(8'h02, 1'b1, "R9");
    bus_start();
    send_byte(8'h2B, 1'b1, "R9");
    m_sda = 1'b1; wt();
    push_exp("R9", 16'd0);
    observe({15'd0, sda_line});
    repeat (TMO + 20) @(negedge clk);
    push_exp("R9", 16'd1);
    observe({15'd0, sda_line});
    wr_reg(8'h01, 8'h02, "R9"); mf = 3'd2; chk_outs("R9");

    wt();
    if (exp_val.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_val.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule